// File: doc/BRIEF.md
# Accumulator Processor with Index Register

A small multicycle stored-program processor built around one 16-bit accumulator, one 11-bit index register and an 11-bit program counter. Instructions and data share one synchronous single-port memory. That memory returns read data on the cycle after the address is presented. Every instruction word carries a 4-bit opcode in bits 15:12, an index flag in bit 11 and an 11-bit address field in bits 10:0.

Two features set it apart from a plain accumulator machine. The first is indexed operand addressing, together with a loop branch that tests the index register for zero and otherwise increments it. The second is a pair of instructions that read or overwrite only the address field of a memory word. With these, a program can rewrite the operand address of its own instructions. The core runs until it decodes a halt opcode. It then raises `halted` and stays there until reset. `ac_dbg` shows the accumulator at all times.

The control is one state machine with five states. FETCH presents PC to memory. DECODE captures the returned word into the instruction register and advances PC. MEMORY presents the operand address. EXECUTE updates the registers and performs any memory write. HALTED is terminal. The transitions are:
- FETCH→DECODE
- DECODE→MEMORY for operand instructions
- DECODE→EXECUTE for register-only instructions
- DECODE→HALTED for the halt opcodes
- MEMORY→EXECUTE
- EXECUTE→FETCH

Top module: `acc_cpu`

## Requirements
- R1: After reset PC, AC and IX are zero. `halted` is low, `mem_we` is low, and the first fetch presents address 0.
- R2: Opcodes 1 (LOAD), 2 (STORE), 3 (ADD) and 4 (SUB) read M[x] into AC, write AC to M[x], add M[x] to AC, and subtract M[x] from AC, in that order. Arithmetic wraps modulo 2^16.
- R3: Opcode 5 shifts AC left by one bit and opcode 6 shifts AC right by one bit. Both shifts fill with zero.
- R4: Opcode 7 loads PC with x unconditionally. Opcode 8 loads PC with x only when AC bit 15 is 0.
- R5: Opcode 9 sets AC to bits 10:0 of M[x], zero-extended. Opcode 10 rewrites M[x] with bits 15:11 kept and bits 10:0 taken from AC.
- R6: An instruction word whose address field was rewritten by opcode 10 uses the new address when it is next fetched.
- R7: When bit 11 is set, LOAD and ADD use the operand address (x + IX) mod 2^11.
- R8: Opcode 11 jumps to x when IX is zero. Otherwise it falls through and IX becomes (IX + 1) mod 2^11.
- R9: Opcode 12 loads bits 10:0 of M[x] into IX. Opcode 13 writes IX to M[x], zero-extended. Opcode 14 adds the field x to IX modulo 2^11. None of these three changes AC.
- R10: Opcodes 0 and 15 halt. `halted` then stays high, and no memory write occurs until reset.
- R11: An instruction with a memory operand (opcodes 1, 2, 3, 4, 9, 10, 12, 13) takes 4 cycles. Opcodes 5, 6, 7, 8, 11 and 14 take 3 cycles. A halt takes 2 cycles before `halted` rises.
- R12: `mem_we` is high only in the EXECUTE cycle of opcodes 2, 10 and 13. Each of these writes exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 11 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| halted | output | 1 | High once a halt opcode has been decoded |
| ac_dbg | output | 16 | Current accumulator value |

## Verification
A corrupted AC or IX reaches the ports at the next store. That store is at most a few instructions away in every test program, so the scoreboard sees a wrong write address or write datum. A stray or missing write shows up in the same cycle as a queue mismatch. A wrong branch decision surfaces as a write that was skipped or should not have happened. A wrong state sequence surfaces in two ways: the cycle count from reset to `halted` no longer matches the per-opcode budget, and the checker flags an illegal successor state on the very next edge.

// File: rtl/acc_pkg.sv
package acc_pkg;

    parameter int WORD_W = 16;
    parameter int OP_W   = 4;
    localparam int ADR_W = WORD_W - OP_W - 1;
    localparam int XBIT  = ADR_W;

    typedef enum logic [OP_W-1:0] {
        OP_HALT  = 4'h0,
        OP_LOAD  = 4'h1,
        OP_STORE = 4'h2,
        OP_ADD   = 4'h3,
        OP_SUB   = 4'h4,
        OP_SHL   = 4'h5,
        OP_SHR   = 4'h6,
        OP_JUMP  = 4'h7,
        OP_JGE   = 4'h8,
        OP_LDADR = 4'h9,
        OP_STADR = 4'hA,
        OP_JZI   = 4'hB,
        OP_LDI   = 4'hC,
        OP_STI   = 4'hD,
        OP_INCI  = 4'hE,
        OP_RSVD  = 4'hF
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_MEMORY,
        ST_EXECUTE,
        ST_HALTED
    } state_e;

    function automatic logic uses_operand(opcode_e op);
        return (op == OP_LOAD)  || (op == OP_STORE) || (op == OP_ADD) ||
               (op == OP_SUB)   || (op == OP_LDADR) || (op == OP_STADR) ||
               (op == OP_LDI)   || (op == OP_STI);
    endfunction

    function automatic logic writes_memory(opcode_e op);
        return (op == OP_STORE) || (op == OP_STADR) || (op == OP_STI);
    endfunction

    function automatic logic stops_core(opcode_e op);
        return (op == OP_HALT) || (op == OP_RSVD);
    endfunction

endpackage

// File: rtl/acc_fsm.sv
module acc_fsm
    import acc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] fetched_op,
    output state_e          state,
    output logic            decode_slot,
    output logic            exec_slot,
    output logic            halted
);

    state_e state_q;
    state_e state_d;
    opcode_e dec_op;

    assign dec_op = opcode_e'(fetched_op);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:   state_d = ST_DECODE;
            ST_DECODE: begin
                if (stops_core(dec_op)) begin
                    state_d = ST_HALTED;
                end else if (uses_operand(dec_op)) begin
                    state_d = ST_MEMORY;
                end else begin
                    state_d = ST_EXECUTE;
                end
            end
            ST_MEMORY:  state_d = ST_EXECUTE;
            ST_EXECUTE: state_d = ST_FETCH;
            ST_HALTED:  state_d = ST_HALTED;
            default:    state_d = ST_FETCH;
        endcase
    end

    // Outputs
    always_comb begin
        decode_slot = 1'b0;
        exec_slot   = 1'b0;
        halted      = 1'b0;
        unique case (state_q)
            ST_DECODE:  decode_slot = 1'b1;
            ST_EXECUTE: exec_slot   = 1'b1;
            ST_HALTED:  halted      = 1'b1;
            default: ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
(
    input  opcode_e           op,
    input  logic [WORD_W-1:0] ac,
    input  logic [WORD_W-1:0] operand,
    output logic [WORD_W-1:0] ac_next,
    output logic              ac_write,
    output logic              ac_nonneg
);

    assign ac_nonneg = ~ac[WORD_W-1];

    always_comb begin
        ac_next  = ac;
        ac_write = 1'b1;
        unique case (op)
            OP_LOAD:  ac_next = operand;
            OP_ADD:   ac_next = ac + operand;
            OP_SUB:   ac_next = ac - operand;
            OP_SHL:   ac_next = {ac[WORD_W-2:0], 1'b0};
            OP_SHR:   ac_next = {1'b0, ac[WORD_W-1:1]};
            OP_LDADR: ac_next = {{(WORD_W-ADR_W){1'b0}}, operand[ADR_W-1:0]};
            default:  ac_write = 1'b0;
        endcase
    end

endmodule

// File: rtl/acc_idx.sv
module acc_idx
    import acc_pkg::*;
(
    input  opcode_e          op,
    input  logic             idx_flag,
    input  logic [ADR_W-1:0] ix,
    input  logic [ADR_W-1:0] field,
    input  logic [ADR_W-1:0] operand_low,
    output logic [ADR_W-1:0] eff_addr,
    output logic [ADR_W-1:0] ix_next,
    output logic             ix_write,
    output logic             ix_zero
);

    logic indexable;

    assign indexable = (op == OP_LOAD) || (op == OP_ADD);
    assign eff_addr  = (indexable && idx_flag) ? field + ix : field;
    assign ix_zero   = (ix == '0);

    always_comb begin
        ix_next  = ix;
        ix_write = 1'b0;
        unique case (op)
            OP_LDI: begin
                ix_next  = operand_low;
                ix_write = 1'b1;
            end
            OP_INCI: begin
                ix_next  = ix + field;
                ix_write = 1'b1;
            end
            OP_JZI: begin
                ix_next  = ix + 1'b1;
                ix_write = !ix_zero;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADR_W-1:0]  mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              halted,
    output logic [WORD_W-1:0] ac_dbg
);

    state_e            state_q;
    logic              decode_slot;
    logic              exec_slot;
    logic [ADR_W-1:0]  pc_q;
    logic [ADR_W-1:0]  ix_q;
    logic [WORD_W-1:0] ac_q;
    logic [WORD_W-1:0] ir_q;

    opcode_e           ir_op;
    logic              ir_xflag;
    logic [ADR_W-1:0]  ir_field;

    logic [WORD_W-1:0] ac_next;
    logic              ac_write;
    logic              ac_nonneg;
    logic [ADR_W-1:0]  eff_addr;
    logic [ADR_W-1:0]  ix_next;
    logic              ix_write;
    logic              ix_zero;
    logic              pc_load;

    assign ir_op    = opcode_e'(ir_q[WORD_W-1 -: OP_W]);
    assign ir_xflag = ir_q[XBIT];
    assign ir_field = ir_q[ADR_W-1:0];

    acc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetched_op  (mem_rdata[WORD_W-1 -: OP_W]),
        .state       (state_q),
        .decode_slot (decode_slot),
        .exec_slot   (exec_slot),
        .halted      (halted)
    );

    acc_alu u_alu (
        .op        (ir_op),
        .ac        (ac_q),
        .operand   (mem_rdata),
        .ac_next   (ac_next),
        .ac_write  (ac_write),
        .ac_nonneg (ac_nonneg)
    );

    acc_idx u_idx (
        .op          (ir_op),
        .idx_flag    (ir_xflag),
        .ix          (ix_q),
        .field       (ir_field),
        .operand_low (mem_rdata[ADR_W-1:0]),
        .eff_addr    (eff_addr),
        .ix_next     (ix_next),
        .ix_write    (ix_write),
        .ix_zero     (ix_zero)
    );

    always_comb begin
        pc_load = 1'b0;
        if (exec_slot) begin
            unique case (ir_op)
                OP_JUMP: pc_load = 1'b1;
                OP_JGE:  pc_load = ac_nonneg;
                OP_JZI:  pc_load = ix_zero;
                default: pc_load = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
            ac_q <= '0;
            ix_q <= '0;
            ir_q <= '0;
        end else begin
            if (decode_slot) begin
                ir_q <= mem_rdata;
                pc_q <= pc_q + 1'b1;
            end
            if (exec_slot && ac_write) begin
                ac_q <= ac_next;
            end
            if (exec_slot && ix_write) begin
                ix_q <= ix_next;
            end
            if (pc_load) begin
                pc_q <= ir_field;
            end
        end
    end

    // Memory port driven from the state
    always_comb begin
        mem_addr  = pc_q;
        mem_wdata = '0;
        mem_we    = 1'b0;
        unique case (state_q)
            ST_FETCH:  mem_addr = pc_q;
            ST_MEMORY: mem_addr = eff_addr;
            ST_EXECUTE: begin
                mem_addr = eff_addr;
                mem_we   = writes_memory(ir_op);
                unique case (ir_op)
                    OP_STORE: mem_wdata = ac_q;
                    OP_STADR: mem_wdata = {mem_rdata[WORD_W-1:ADR_W], ac_q[ADR_W-1:0]};
                    OP_STI:   mem_wdata = {{(WORD_W-ADR_W){1'b0}}, ix_q};
                    default:  mem_wdata = '0;
                endcase
            end
            default: mem_addr = pc_q;
        endcase
    end

    assign ac_dbg = ac_q;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              halted,
    input logic              mem_we,
    input state_e            state,
    input opcode_e           op,
    input logic [ADR_W-1:0]  ix,
    input logic [WORD_W-1:0] ac
);

    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    p_halt_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    p_fetch_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (state == ST_DECODE));

    p_memory_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MEMORY) |=> (state == ST_EXECUTE));

    p_execute_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXECUTE) |=> (state == ST_FETCH));

    p_write_slot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (state == ST_EXECUTE && $past(state) == ST_MEMORY));

    p_jzi_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXECUTE && op == OP_JZI && ix != '0)
            |=> (ix == ADR_W'($past(ix) + 1'b1)));

    p_ix_ops_keep_ac_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXECUTE && (op == OP_INCI || op == OP_JZI ||
                                 op == OP_LDI  || op == OP_STI))
            |=> $stable(ac));

endmodule

bind acc_cpu acc_cpu_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .halted (halted),
    .mem_we (mem_we),
    .state  (state_q),
    .op     (ir_op),
    .ix     (ix_q),
    .ac     (ac_q)
);

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [15:0] mem_rdata;
    logic        halted;
    logic [15:0] ac_dbg;

    logic [15:0] ram [0:2047];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [10:0] a;
        logic [15:0] d;
        string       req;
    } wr_t;

    wr_t expq[$];
    wr_t got;

    always #2 clk = ~clk;

    acc_cpu u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .halted    (halted),
        .ac_dbg    (ac_dbg)
    );

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr];
    end

    function automatic logic [15:0] enc(input int op, input bit x, input int a);
        return {op[3:0], x, a[10:0]};
    endfunction

    task automatic expect_wr(input logic [10:0] a, input logic [15:0] d, input string req);
        wr_t e;
        e.a = a;
        e.d = d;
        e.req = req;
        expq.push_back(e);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: pop and compare every write
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            checks++;
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL R12 unexpected write: actual=%h:%h expected=none",
                         mem_addr, mem_wdata);
            end else begin
                got = expq.pop_front();
                if (mem_addr !== got.a || mem_wdata !== got.d) begin
                    fails++;
                    $display("FAIL %s write: actual=%h:%h expected=%h:%h",
                             got.req, mem_addr, mem_wdata, got.a, got.d);
                end
            end
        end
    end

    task automatic clear_ram();
        for (int i = 0; i < 2048; i++) ram[i] = 16'h0000;
    endtask

    task automatic run_to_halt(input int budget, output int cycles);
        cycles = 0;
        while (!halted && cycles < budget) begin
            @(negedge clk);
            cycles++;
        end
        if (!halted) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog: actual=%0d expected halt", cycles);
        end
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int cyc;
        logic [15:0] ac_hold;

        // Program A: arithmetic, shifts, conditional and unconditional jumps
        clear_ram();
        ram[0]  = enc(1, 0, 'h100);
        ram[1]  = enc(3, 0, 'h101);
        ram[2]  = enc(2, 0, 'h200);
        ram[3]  = enc(4, 0, 'h102);
        ram[4]  = enc(2, 0, 'h201);
        ram[5]  = enc(5, 0, 0);
        ram[6]  = enc(2, 0, 'h202);
        ram[7]  = enc(6, 0, 0);
        ram[8]  = enc(2, 0, 'h203);
        ram[9]  = enc(1, 0, 'h103);
        ram[10] = enc(3, 0, 'h101);
        ram[11] = enc(2, 0, 'h204);
        ram[12] = enc(8, 0, 14);
        ram[13] = enc(2, 0, 'h205);
        ram[14] = enc(4, 0, 'h101);
        ram[15] = enc(8, 0, 17);
        ram[16] = enc(2, 0, 'h206);
        ram[17] = enc(7, 0, 19);
        ram[18] = enc(2, 0, 'h207);
        ram[19] = enc(0, 0, 0);
        ram['h100] = 16'h7FFF;
        ram['h101] = 16'h0001;
        ram['h102] = 16'h0003;
        ram['h103] = 16'hFFFF;

        expect_wr('h200, 16'h8000, "R2");
        expect_wr('h201, 16'h7FFD, "R2");
        expect_wr('h202, 16'hFFFA, "R3");
        expect_wr('h203, 16'h7FFD, "R3");
        expect_wr('h204, 16'h0000, "R2");
        expect_wr('h206, 16'hFFFF, "R4");

        repeat (3) @(negedge clk);
        chk(halted == 1'b0, "R1", "halted in reset", 32'(halted), 0);
        chk(ac_dbg == 16'h0, "R1", "AC in reset", 32'(ac_dbg), 0);
        chk(mem_we == 1'b0, "R1", "write enable in reset", 32'(mem_we), 0);
        rst_n = 1'b1;
        chk(mem_addr == 11'h0, "R1", "first fetch address", 32'(mem_addr), 0);

        run_to_halt(2000, cyc);
        chk(cyc == 65, "R11", "cycles to halt A", 32'(cyc), 65);
        chk(ac_dbg == 16'hFFFF, "R2", "final AC A", 32'(ac_dbg), 32'hFFFF);
        chk(expq.size() == 0, "R12", "pending writes A", 32'(expq.size()), 0);

        ac_hold = ac_dbg;
        repeat (10) @(negedge clk);
        chk(halted == 1'b1, "R10", "halted held", 32'(halted), 1);
        chk(ac_dbg == ac_hold, "R10", "AC frozen after halt", 32'(ac_dbg), 32'(ac_hold));

        // Program B: address-field access, self-modification, indexing, IX ops
        enter_reset();
        chk(ac_dbg == 16'h0, "R1", "AC cleared by reset", 32'(ac_dbg), 0);
        clear_ram();
        ram[0]  = enc(9,  0, 'h300);
        ram[1]  = enc(2,  0, 'h210);
        ram[2]  = enc(1,  0, 'h301);
        ram[3]  = enc(10, 0, 5);
        ram[4]  = enc(10, 0, 'h300);
        ram[5]  = enc(1,  0, 'h7FF);
        ram[6]  = enc(2,  0, 'h211);
        ram[7]  = enc(12, 0, 'h303);
        ram[8]  = enc(13, 0, 'h212);
        ram[9]  = enc(14, 0, 'h7FE);
        ram[10] = enc(13, 0, 'h213);
        ram[11] = enc(2,  0, 'h214);
        ram[12] = enc(1,  1, 'h310);
        ram[13] = enc(3,  1, 'h7FF);
        ram[14] = enc(2,  0, 'h215);
        ram[15] = enc(12, 0, 'h304);
        ram[16] = enc(11, 0, 19);
        ram[17] = enc(11, 0, 19);
        ram[18] = enc(11, 0, 20);
        ram[19] = enc(2,  0, 'h216);
        ram[20] = enc(13, 0, 'h217);
        ram[21] = enc(15, 0, 0);
        ram['h300] = 16'hABCD;
        ram['h301] = 16'h0302;
        ram['h302] = 16'h1234;
        ram['h303] = 16'hF805;
        ram['h304] = 16'h07FE;
        ram['h310] = 16'h9999;
        ram['h313] = 16'h0050;
        ram['h7FF] = 16'hDEAD;

        expect_wr('h210, 16'h03CD, "R5");
        expect_wr('h005, 16'h1302, "R5");
        expect_wr('h300, 16'hAB02, "R5");
        expect_wr('h211, 16'h1234, "R6");
        expect_wr('h212, 16'h0005, "R9");
        expect_wr('h213, 16'h0003, "R9");
        expect_wr('h214, 16'h1234, "R9");
        expect_wr('h215, 16'h1351, "R7");
        expect_wr('h217, 16'h0000, "R8");

        rst_n = 1'b1;
        run_to_halt(2000, cyc);
        chk(cyc == 78, "R11", "cycles to halt B", 32'(cyc), 78);
        chk(ac_dbg == 16'h1351, "R7", "final AC B", 32'(ac_dbg), 32'h1351);
        chk(ram[5] == 16'h1302, "R6", "rewritten instruction word", 32'(ram[5]), 32'h1302);
        chk(expq.size() == 0, "R12", "pending writes B", 32'(expq.size()), 0);
        repeat (6) @(negedge clk);
        chk(halted == 1'b1, "R10", "reserved opcode halts", 32'(halted), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R10 global watchdog: actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule